// File: doc/BRIEF.md
# BCD Calendar Core with Init Handshake

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, month, a two-digit year and a weekday numbered 1 (Monday) to 7 (Sunday). A two-stage divider turns the block clock into a once-per-second advance. The asynchronous stage counts 0..A and the synchronous stage counts 0..S, so one second lasts (A+1)*(S+1) clock cycles.

Software reaches the block through a flat word interface with four words: time, date, divider and status. Reads are combinational from the address. To set the clock, software raises the init request bit and waits for the init-active flag. While that flag is high, counting is frozen and the time, date and divider words accept writes. Clearing the request lets counting restart from a fresh divider phase. The synchronised flag can be cleared by software and is raised by hardware shortly after each seconds advance and after init mode is left. A further status bit shows whether the calendar has been set, taken as a non-zero year.

Top module: `cal_calendar`

## Requirements
- R1: After reset the time word reads 0x000000, the date word reads 0x002101 (day 01, month 01, weekday 1, year 00), the divider word reads 0x7F00FF and the status word reads 0x000000.
- R2: Address 3 is status. Writing bit 7 sets or clears the init request, which reads back in bit 7. Bit 6 (init active) rises at the second clock edge after the edge that sets the request and falls at the first edge after the request is cleared. While bit 6 or bit 7 is high, the time word does not advance.
- R3: Writes to the time word (address 0), the date word (address 1) and the divider word (address 2) take effect only while status bit 6 is high; at any other time they are ignored.
- R4: The divider word holds S in bits 14:0 and A in bits 22:16. Let E be the edge at which init active falls. The seconds advance at edge E + n*(A+1)*(S+1) for n = 1, 2, ...
- R5: The time word holds BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Seconds and minutes wrap from 59 to 00 and carry; hours wrap from 23 to 00 and carry into the date.
- R6: The date word holds BCD day in bits 5:0, month in bits 12:8, weekday in bits 15:13 and year in bits 23:16. The day wraps to 01 after 28/29 (February, with a leap year when the year is divisible by 4), 30 (April, June, September, November) or 31 (other months). The month wraps from 12 to 01 and the year from 99 to 00.
- R7: The weekday advances on the same edge as the day of month and wraps from 7 to 1.
- R8: Status bit 5 (synchronised) is cleared by a status write with bit 5 at 0; a write with bit 5 at 1 leaves it unchanged. It is set on the second edge after the edge that clears init active's request, and on the first edge after every seconds advance.
- R9: Status bit 4 reads 1 exactly when the year field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider input |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Word select: 0 time, 1 date, 2 divider, 3 status |
| regWr | input | 1 | Write strobe, sampled on the rising clock edge |
| regWdata | input | 24 | Write data |
| regRdata | output | 24 | Read data of the selected word, combinational |

## Verification
A corrupted BCD digit or a missed carry shows on the time or date word at the very next seconds advance, so the bench runs a full day at one advance per cycle and compares every second against an arithmetic count. Month-length and year-wrap faults only appear at the end of a month, so every month of several leap and non-leap years is started one second before midnight on its last day and the day before it. A handshake or divider fault moves the init-active flag, the synchronised flag or the first seconds advance by a cycle or more, and the bench samples those at exact cycles after each status write.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  localparam int WORD_W = 24;

  localparam logic [1:0] ADDR_TIME   = 2'd0;
  localparam logic [1:0] ADDR_DATE   = 2'd1;
  localparam logic [1:0] ADDR_DIV    = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam int ST_INIT_REQ = 7;
  localparam int ST_INIT_ACT = 6;
  localparam int ST_SYNCED   = 5;
  localparam int ST_CAL_SET  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic loadTime;
    logic loadDate;
  } calStrobe_t;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [4:0] month;
    logic [5:0] mday;
    logic [5:0] hours;
    logic [6:0] mins;
    logic [6:0] secs;
  } calFields_t;

  function automatic logic [7:0] bcdInc8(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc8 = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc8 = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last BCD day of a BCD month; leap when the BCD year is a multiple of 4
  function automatic logic [5:0] monthEnd(input logic [4:0] m, input logic [7:0] y);
    logic leap;
    if (y[4]) leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    case (m)
      5'h02:                      monthEnd = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: monthEnd = 6'h30;
      default:                    monthEnd = 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_bcd_field.sv
`timescale 1ns/1ps
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter int         W        = 7,
  parameter logic [7:0] RST_VAL  = 8'h00,
  parameter logic [7:0] WRAP_VAL = 8'h00
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  input  logic [W-1:0] maxVal,
  output logic [W-1:0] value,
  output logic         atMax
);

  logic [7:0] wide;
  logic [7:0] nextWide;

  always_comb begin
    wide     = 8'(value);
    nextWide = bcdInc8(wide);
  end

  assign atMax = (value >= maxVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     value <= RST_VAL[W-1:0];
    else if (load) value <= loadVal;
    else if (inc)  value <= atMax ? WRAP_VAL[W-1:0] : nextWide[W-1:0];
  end

endmodule

// File: rtl/cal_datapath.sv
`timescale 1ns/1ps
module cal_datapath
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  input  calFields_t wrFields,
  output calFields_t curr
);

  logic secMax, minMax, hourMax, dayMax, monMax, yearMax;
  logic incMin, incHour, incDay, incMon, incYear;
  logic [5:0] dayLimit;

  assign incMin  = strobe.tick & secMax;
  assign incHour = incMin & minMax;
  assign incDay  = incHour & hourMax;
  assign incMon  = incDay & dayMax;
  assign incYear = incMon & monMax;
  assign dayLimit = monthEnd(curr.month, curr.year);

  cal_bcd_field #(.W(7), .RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_sec (
    .clk(clk), .rstN(rstN), .load(strobe.loadTime), .loadVal(wrFields.secs),
    .inc(strobe.tick), .maxVal(7'h59), .value(curr.secs), .atMax(secMax));

  cal_bcd_field #(.W(7), .RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_min (
    .clk(clk), .rstN(rstN), .load(strobe.loadTime), .loadVal(wrFields.mins),
    .inc(incMin), .maxVal(7'h59), .value(curr.mins), .atMax(minMax));

  cal_bcd_field #(.W(6), .RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_hour (
    .clk(clk), .rstN(rstN), .load(strobe.loadTime), .loadVal(wrFields.hours),
    .inc(incHour), .maxVal(6'h23), .value(curr.hours), .atMax(hourMax));

  cal_bcd_field #(.W(6), .RST_VAL(8'h01), .WRAP_VAL(8'h01)) u_day (
    .clk(clk), .rstN(rstN), .load(strobe.loadDate), .loadVal(wrFields.mday),
    .inc(incDay), .maxVal(dayLimit), .value(curr.mday), .atMax(dayMax));

  cal_bcd_field #(.W(5), .RST_VAL(8'h01), .WRAP_VAL(8'h01)) u_mon (
    .clk(clk), .rstN(rstN), .load(strobe.loadDate), .loadVal(wrFields.month),
    .inc(incMon), .maxVal(5'h12), .value(curr.month), .atMax(monMax));

  cal_bcd_field #(.W(8), .RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_year (
    .clk(clk), .rstN(rstN), .load(strobe.loadDate), .loadVal(wrFields.year),
    .inc(incYear), .maxVal(8'h99), .value(curr.year), .atMax(yearMax));

  // weekday: binary 1..7, advances with the day of month
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curr.wday <= 3'd1;
    else if (strobe.loadDate) curr.wday <= wrFields.wday;
    else if (incDay)          curr.wday <= (curr.wday >= 3'd7) ? 3'd1 : curr.wday + 3'd1;
  end

  logic unusedYearMax;
  assign unusedYearMax = yearMax;

endmodule

// File: rtl/cal_ctrl.sv
`timescale 1ns/1ps
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int                 ASYNC_W   = 7,
  parameter int                 SYNC_W    = 15,
  parameter logic [ASYNC_W-1:0] ASYNC_RST = '1,
  parameter logic [SYNC_W-1:0]  SYNC_RST  = SYNC_W'(255)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic               wrInitBit,
  input  logic               wrSyncBit,
  input  logic [ASYNC_W-1:0] wrAsync,
  input  logic [SYNC_W-1:0]  wrSyncDiv,
  output calStrobe_t         strobe,
  output logic               initReq,
  output logic               initActive,
  output logic               syncFlag,
  output logic [ASYNC_W-1:0] aDiv,
  output logic [SYNC_W-1:0]  sDiv
);

  logic wrStatus, wrDiv, reqDly, exitPulse, running, refreshDly, tick;
  logic [ASYNC_W-1:0] aCnt;
  logic [SYNC_W-1:0]  sCnt;

  assign wrStatus  = regWr && (regAddr == ADDR_STATUS);
  assign wrDiv     = regWr && (regAddr == ADDR_DIV) && initActive;
  assign exitPulse = initActive && !initReq;
  assign running   = !initReq && !initActive;
  assign tick      = running && (aCnt == aDiv) && (sCnt == sDiv);

  always_comb begin
    strobe.tick     = tick;
    strobe.loadTime = regWr && (regAddr == ADDR_TIME) && initActive;
    strobe.loadDate = regWr && (regAddr == ADDR_DATE) && initActive;
  end

  // init request / acknowledge, two edges to enter, one to leave
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReq    <= 1'b0;
      reqDly     <= 1'b0;
      initActive <= 1'b0;
    end else begin
      if (wrStatus) initReq <= wrInitBit;
      reqDly     <= initReq;
      initActive <= initReq && reqDly;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aDiv <= ASYNC_RST;
      sDiv <= SYNC_RST;
    end else if (wrDiv) begin
      aDiv <= wrAsync;
      sDiv <= wrSyncDiv;
    end
  end

  // two-stage divider, phase restarts whenever counting is frozen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aCnt <= '0;
      sCnt <= '0;
    end else if (!running) begin
      aCnt <= '0;
      sCnt <= '0;
    end else if (aCnt == aDiv) begin
      aCnt <= '0;
      sCnt <= (sCnt == sDiv) ? '0 : sCnt + 1'b1;
    end else begin
      aCnt <= aCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshDly <= 1'b0;
      syncFlag   <= 1'b0;
    end else begin
      refreshDly <= tick || exitPulse;
      if (refreshDly)                  syncFlag <= 1'b1;
      else if (wrStatus && !wrSyncBit) syncFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/cal_calendar.sv
`timescale 1ns/1ps
module cal_calendar
  import cal_pkg::*;
#(
  parameter int                 ASYNC_W   = 7,
  parameter int                 SYNC_W    = 15,
  parameter logic [ASYNC_W-1:0] ASYNC_RST = 7'h7F,
  parameter logic [SYNC_W-1:0]  SYNC_RST  = 15'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata
);

  calStrobe_t strobe;
  calFields_t wrFields, curr;
  logic initReq, initActive, syncFlag, yearNz;
  logic [ASYNC_W-1:0] aDiv;
  logic [SYNC_W-1:0]  sDiv;
  logic [WORD_W-1:0]  timeWord, dateWord, divWord, statusWord;

  always_comb begin
    wrFields.secs  = regWdata[6:0];
    wrFields.mins  = regWdata[14:8];
    wrFields.hours = regWdata[21:16];
    wrFields.mday  = regWdata[5:0];
    wrFields.month = regWdata[12:8];
    wrFields.wday  = regWdata[15:13];
    wrFields.year  = regWdata[23:16];
  end

  cal_ctrl #(
    .ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W), .ASYNC_RST(ASYNC_RST), .SYNC_RST(SYNC_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .wrInitBit(regWdata[ST_INIT_REQ]), .wrSyncBit(regWdata[ST_SYNCED]),
    .wrAsync(regWdata[16 +: ASYNC_W]), .wrSyncDiv(regWdata[0 +: SYNC_W]),
    .strobe(strobe), .initReq(initReq), .initActive(initActive), .syncFlag(syncFlag),
    .aDiv(aDiv), .sDiv(sDiv)
  );

  cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrFields(wrFields), .curr(curr)
  );

  assign yearNz = (curr.year != 8'h00);

  always_comb begin
    timeWord   = {2'b00, curr.hours, 1'b0, curr.mins, 1'b0, curr.secs};
    dateWord   = {curr.year, curr.wday, curr.month, 2'b00, curr.mday};
    statusWord = '0;
    statusWord[ST_INIT_REQ] = initReq;
    statusWord[ST_INIT_ACT] = initActive;
    statusWord[ST_SYNCED]   = syncFlag;
    statusWord[ST_CAL_SET]  = yearNz;
    divWord = '0;
    divWord[16 +: ASYNC_W] = aDiv;
    divWord[0 +: SYNC_W]   = sDiv;
    case (regAddr)
      ADDR_TIME: regRdata = timeWord;
      ADDR_DATE: regRdata = dateWord;
      ADDR_DIV:  regRdata = divWord;
      default:   regRdata = statusWord;
    endcase
  end

endmodule

// File: rtl/cal_calendar_chk.sv
`timescale 1ns/1ps
module cal_calendar_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [1:0]  regAddr,
  input logic        tick,
  input logic [23:0] statusWord,
  input logic [23:0] timeWord,
  input logic [23:0] dateWord
);

  a_r2_active_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[6] |-> $past(statusWord[7]));

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[7] && !(regWr && regAddr == 2'd0)) |=> $stable(timeWord));

  a_r4_no_tick_in_init: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (!statusWord[7] && !statusWord[6]));

  a_r3_time_locked: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && !statusWord[6] && !tick) |=> $stable(timeWord));

  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && timeWord[6:0] == 7'h59) |=> (timeWord[6:0] == 7'h00));

  a_r7_wday_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && timeWord[21:0] == 22'h235959 && dateWord[15:13] == 3'd7)
      |=> (dateWord[15:13] == 3'd1));

endmodule

bind cal_calendar cal_calendar_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .tick(strobe.tick),
  .statusWord(statusWord), .timeWord(timeWord), .dateWord(dateWord)
);

// File: tb/cal_calendar_tb.sv
`timescale 1ns/1ps
module cal_calendar_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWr = 1'b0;
  logic [23:0] regWdata = '0;
  logic [23:0] regRdata;

  int checks = 0;
  int errors = 0;

  cal_calendar u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [23:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [23:0] bcd(input int v);
    return 24'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [23:0] timeOf(input int s);
    return (bcd(s / 3600) << 16) | (bcd((s / 60) % 60) << 8) | bcd(s % 60);
  endfunction

  function automatic logic [23:0] dateOf(input int y, input int m, input int d, input int w);
    return (bcd(y) << 16) | 24'(w << 13) | (bcd(m) << 8) | bcd(d);
  endfunction

  function automatic int daysIn(input int y, input int m);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic enterInit();
    wrReg(2'd3, 24'h000080);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] r, s, prev;
    int yrs [9] = '{0, 1, 2, 3, 4, 20, 23, 96, 99};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdReg(2'd0, r); chk("R1", "time", r, 24'h000000);
    rdReg(2'd1, r); chk("R1", "date", r, 24'h002101);
    rdReg(2'd2, r); chk("R1", "divider", r, 24'h7F00FF);
    rdReg(2'd3, r); chk("R1", "status", r, 24'h000000);

    // R3 writes outside init are ignored
    wrReg(2'd0, 24'h123456); rdReg(2'd0, r); chk("R3", "time locked", r, 24'h000000);
    wrReg(2'd1, 24'h991231); rdReg(2'd1, r); chk("R3", "date locked", r, 24'h002101);
    wrReg(2'd2, 24'h000000); rdReg(2'd2, r); chk("R3", "divider locked", r, 24'h7F00FF);

    // R2 handshake timing
    wrReg(2'd3, 24'h000080);
    rdReg(2'd3, r); chk("R2", "req bit", {23'b0, r[7]}, 24'd1);
    chk("R2", "active after 1 edge", {23'b0, r[6]}, 24'd0);
    @(negedge clk); rdReg(2'd3, r); chk("R2", "active after 2 edges-1", {23'b0, r[6]}, 24'd0);
    @(negedge clk); rdReg(2'd3, r); chk("R2", "active after 2 edges", {23'b0, r[6]}, 24'd1);

    // R2 freeze while loaded with fastest divider
    wrReg(2'd2, 24'h000000);
    wrReg(2'd0, 24'h000010);
    repeat (30) @(negedge clk);
    rdReg(2'd0, r); chk("R2", "frozen in init", r, 24'h000010);
    rdReg(2'd2, r); chk("R3", "divider written in init", r, 24'h000000);

    // R4 divider A=2 S=1 -> 6 cycles per second; R8 sync after exit
    wrReg(2'd2, 24'h020001);
    wrReg(2'd0, 24'h000000);
    wrReg(2'd3, 24'h000000);
    for (int k = 1; k <= 14; k++) begin
      if (k > 1) @(negedge clk);
      rdReg(2'd0, r);
      chk("R4", $sformatf("seconds at cycle %0d", k), r, bcd((k >= 2) ? (k - 2) / 6 : 0));
      rdReg(2'd3, s);
      chk("R8", $sformatf("sync at cycle %0d", k), {23'b0, s[5]}, (k >= 3) ? 24'd1 : 24'd0);
      chk("R2", $sformatf("active at cycle %0d", k), {23'b0, s[6]}, (k == 1) ? 24'd1 : 24'd0);
    end

    // R8 clear, write-one ignored, set after an advance
    rdReg(2'd0, prev);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rdReg(2'd0, r);
      if (r != prev) break;
    end
    wrReg(2'd3, 24'h000000);
    rdReg(2'd3, s); chk("R8", "cleared by write 0", {23'b0, s[5]}, 24'd0);
    wrReg(2'd3, 24'h000020);
    rdReg(2'd3, s); chk("R8", "write 1 no effect", {23'b0, s[5]}, 24'd0);
    rdReg(2'd0, prev);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rdReg(2'd0, r);
      if (r != prev) break;
    end
    rdReg(2'd3, s); chk("R8", "not yet set on advance edge", {23'b0, s[5]}, 24'd0);
    @(negedge clk);
    rdReg(2'd3, s); chk("R8", "set one edge after advance", {23'b0, s[5]}, 24'd1);

    // R5 R7 full day at one second per cycle, starting 28 Feb 2024 weekday 7
    enterInit();
    wrReg(2'd2, 24'h000000);
    wrReg(2'd0, 24'h000000);
    wrReg(2'd1, dateOf(24, 2, 28, 7));
    wrReg(2'd3, 24'h000000);
    for (int k = 1; k <= 86402; k++) begin
      int c;
      if (k > 1) @(negedge clk);
      c = (k >= 2) ? k - 2 : 0;
      rdReg(2'd0, r);
      chk("R5", "time sweep", r, timeOf(c % 86400));
      if (k == 86401) begin
        rdReg(2'd1, r); chk("R7", "before midnight", r, dateOf(24, 2, 28, 7));
      end
    end
    rdReg(2'd1, r); chk("R7", "weekday 7 to 1, leap day", r, dateOf(24, 2, 29, 1));

    // R6 R9 month ends across years
    foreach (yrs[yi]) begin
      for (int m = 1; m <= 12; m++) begin
        for (int v = 0; v < 2; v++) begin
          int y, dim, d0, d1, m1, y1;
          y = yrs[yi];
          dim = daysIn(y, m);
          d0 = (v == 0) ? dim - 1 : dim;
          d1 = (v == 0) ? dim : 1;
          m1 = (v == 0) ? m : ((m == 12) ? 1 : m + 1);
          y1 = (v == 1 && m == 12) ? (y + 1) % 100 : y;
          if (y == 99 && m != 12) continue;
          enterInit();
          wrReg(2'd0, 24'h235959);
          wrReg(2'd1, dateOf(y, m, d0, 3));
          wrReg(2'd3, 24'h000000);
          repeat (2) @(negedge clk);
          rdReg(2'd1, r);
          chk("R6", $sformatf("date after %0d-%0d-%0d", y, m, d0), r, dateOf(y1, m1, d1, 4));
          rdReg(2'd0, r); chk("R5", "midnight", r, 24'h000000);
          rdReg(2'd3, s);
          chk("R9", "calendar set bit", {23'b0, s[4]}, (y1 != 0) ? 24'd1 : 24'd0);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule